// File: doc/BRIEF.md
# Half-Rate Double-Word Assembler

This block sits right behind a deserialising receiver. The receiver delivers two already-decoded bytes on every edge of its receive clock. The block pairs successive half-words into 32-bit double words. It also produces a clock at half the receive rate, which downstream frame logic uses as its operating clock. The output double word is registered, and its comma flag is registered with it.

The receiver flags a comma on half-words that carry a delimiter. That flag decides the pairing. A flagged half-word always becomes the upper half of a new double word, and any half that was waiting is dropped. The comma flag is then carried forward so that it comes out with the finished double word. Frames on the link are double-word aligned, so once the first delimiter has been seen, pairing stays locked. The half-rate clock rises on the same receive edge that presents a new double word. In a locked stream it toggles on every receive edge. Only a comma that arrives on the second half-word can stretch its low phase.

Top module: `half_rate_word_assembler`

## Requirements
- R1: While `rst` is high at a rising edge of `rx_clk`, that edge clears `dw_data` to 0, `dw_comma` to 0 and `half_clk` to 0, and the pairing returns to expecting a first half.
- R2: A finished double word holds the earlier half-word in bits [31:16] and the later half-word in bits [15:0].
- R3: `dw_data` and `dw_comma` change only on the edge that captures the second half of a pair. On every other edge they keep their previous values.
- R4: A half-word that arrives with `rx_comma` = 1 is always taken as the first half of a new pair, whatever the pairing state. A first half that was pending is discarded, and the outputs do not change on that edge.
- R5: `dw_comma` equals the comma flag of the first half of the double word being presented. It is 1 for the whole time that double word is held.
- R6: `half_clk` is 1 exactly in the cycle after an edge that completed a double word, so its rising edge lines up with each output update.
- R7: `half_clk` is 0 in the cycle after an edge that captured a first half. It therefore never stays high for two receive cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; two bytes arrive per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 16 | Decoded half-word from the receiver |
| rx_comma | input | 1 | Comma seen on this half-word |
| half_clk | output | 1 | Generated clock at half the receive rate |
| dw_data | output | 32 | Assembled double word |
| dw_comma | output | 1 | Comma flag travelling with `dw_data` |

## Verification
A first half is captured on one receive edge and becomes visible in `dw_data` one edge later. That second edge both registers the double word and raises `half_clk`, so every result is due exactly one edge after the half-word that completes it. The bench drives each half-word on the falling edge and samples all three outputs 1 ns after the following rising edge. It compares them with a pairing model built from the requirements. Comma offsets are swept from zero to eleven half-words after a locked stream, which places commas on both even and odd positions. Runs of consecutive commas and a reset in the middle of a pair are also covered.

// File: rtl/hrwa_pkg.sv
package hrwa_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

endpackage

// File: rtl/hrwa_phase_ctrl.sv
module hrwa_phase_ctrl
  import hrwa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   comma,
  output phase_e phase,
  output logic   load_first,
  output logic   load_second
);

  phase_e phase_q;

  // a comma always restarts a pair; otherwise the state alternates
  always_comb begin
    load_first  = comma || (phase_q == PH_FIRST);
    load_second = !load_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
    end else if (load_first) begin
      phase_q <= PH_SECOND;
    end else begin
      phase_q <= PH_FIRST;
    end
  end

  assign phase = phase_q;

  AST_COMMA_STARTS_PAIR: assert property (@(posedge clk) disable iff (rst)
    comma |=> (phase_q == PH_SECOND)); // R4

endmodule

// File: rtl/hrwa_half_capture.sv
module hrwa_half_capture
  import hrwa_pkg::*;
#(
  parameter int unsigned HALF_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_first,
  input  logic [HALF_W-1:0] data,
  input  logic              comma,
  output logic [HALF_W-1:0] first_q,
  output logic              comma_q
);

  localparam int unsigned LANES = HALF_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (load_first) begin
        lane_q <= data[g*BYTE_W +: BYTE_W];
      end
    end
    assign first_q[g*BYTE_W +: BYTE_W] = lane_q;
  end

  // comma extender: hold the first-half flag until the pair completes
  always_ff @(posedge clk) begin
    if (rst) begin
      comma_q <= 1'b0;
    end else if (load_first) begin
      comma_q <= comma;
    end
  end

  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_first |=> $stable(first_q)); // R4

endmodule

// File: rtl/hrwa_out_stage.sv
module hrwa_out_stage
  import hrwa_pkg::*;
#(
  parameter int unsigned HALF_W = 16
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_second,
  input  logic [HALF_W-1:0]   first_q,
  input  logic                first_comma,
  input  logic [HALF_W-1:0]   data,
  output logic [2*HALF_W-1:0] dw,
  output logic                dw_comma,
  output logic                hclk
);

  localparam int unsigned LANES = HALF_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (load_second) begin
        hi_q <= first_q[g*BYTE_W +: BYTE_W];
        lo_q <= data[g*BYTE_W +: BYTE_W];
      end
    end
    assign dw[HALF_W + g*BYTE_W +: BYTE_W] = hi_q;
    assign dw[g*BYTE_W +: BYTE_W]          = lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dw_comma <= 1'b0;
      hclk     <= 1'b0;
    end else begin
      hclk <= load_second;
      if (load_second) begin
        dw_comma <= first_comma;
      end
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load_second |=> ($stable(dw) && $stable(dw_comma))); // R3

endmodule

// File: rtl/half_rate_word_assembler.sv
module half_rate_word_assembler
  import hrwa_pkg::*;
#(
  parameter int unsigned HALF_W = 16
)(
  input  logic                rx_clk,
  input  logic                rst,
  input  logic [HALF_W-1:0]   rx_data,
  input  logic                rx_comma,
  output logic                half_clk,
  output logic [2*HALF_W-1:0] dw_data,
  output logic                dw_comma
);

  phase_e            phase;
  logic              load_first;
  logic              load_second;
  logic [HALF_W-1:0] first_q;
  logic              first_comma;

  hrwa_phase_ctrl u_phase (
    .clk         (rx_clk),
    .rst         (rst),
    .comma       (rx_comma),
    .phase       (phase),
    .load_first  (load_first),
    .load_second (load_second)
  );

  hrwa_half_capture #(.HALF_W(HALF_W)) u_first (
    .clk        (rx_clk),
    .rst        (rst),
    .load_first (load_first),
    .data       (rx_data),
    .comma      (rx_comma),
    .first_q    (first_q),
    .comma_q    (first_comma)
  );

  hrwa_out_stage #(.HALF_W(HALF_W)) u_out (
    .clk         (rx_clk),
    .rst         (rst),
    .load_second (load_second),
    .first_q     (first_q),
    .first_comma (first_comma),
    .data        (rx_data),
    .dw          (dw_data),
    .dw_comma    (dw_comma),
    .hclk        (half_clk)
  );

  AST_RESET_CLEARS: assert property (@(posedge rx_clk)
    rst |=> (!half_clk && !dw_comma && dw_data == '0)); // R1

  AST_HCLK_NOT_TWICE: assert property (@(posedge rx_clk) disable iff (rst)
    half_clk |=> !half_clk); // R7

  AST_HCLK_ON_DONE: assert property (@(posedge rx_clk) disable iff (rst)
    (phase == PH_SECOND && !rx_comma) |=> half_clk); // R6

  AST_LOWER_HALF: assert property (@(posedge rx_clk) disable iff (rst)
    (phase == PH_SECOND && !rx_comma) |=> dw_data[HALF_W-1:0] == $past(rx_data)); // R2

endmodule

// File: tb/half_rate_word_assembler_tb.sv
module half_rate_word_assembler_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rx_data = '0;
  logic        rx_comma = 1'b0;
  logic        half_clk;
  logic [31:0] dw_data;
  logic        dw_comma;

  int checks = 0;
  int errors = 0;

  // model state, derived from the requirements
  logic        m_second = 1'b0;
  logic [15:0] m_hi = '0;
  logic        m_hc = 1'b0;
  logic [31:0] m_dw = '0;
  logic        m_c = 1'b0;
  logic        m_h = 1'b0;
  logic [15:0] ctr = 16'h1000;

  always #2 clk = ~clk;

  half_rate_word_assembler u_dut (
    .rx_clk   (clk),
    .rst      (rst),
    .rx_data  (rx_data),
    .rx_comma (rx_comma),
    .half_clk (half_clk),
    .dw_data  (dw_data),
    .dw_comma (dw_comma)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic [15:0] d, input logic c);
    @(negedge clk);
    rst = r; rx_data = d; rx_comma = c;
    @(posedge clk);
    #1;
    if (r) begin
      m_second = 0; m_hi = '0; m_hc = 0; m_dw = '0; m_c = 0; m_h = 0;
      check("R1 dw_data", dw_data, 32'h0);
      check("R1 dw_comma", {31'h0, dw_comma}, 32'h0);
      check("R1 half_clk", {31'h0, half_clk}, 32'h0);
    end else begin
      if (c || !m_second) begin
        m_hi = d; m_hc = c; m_second = 1; m_h = 0;
      end else begin
        m_dw = {m_hi, d}; m_c = m_hc; m_second = 0; m_h = 1;
      end
      check(c ? "R4 dw_data" : (m_h ? "R2 dw_data" : "R3 dw_data"), dw_data, m_dw);
      check("R5 dw_comma", {31'h0, dw_comma}, {31'h0, m_c});
      check(m_h ? "R6 half_clk" : "R7 half_clk", {31'h0, half_clk}, {31'h0, m_h});
    end
  endtask

  task automatic word(input logic c);
    ctr = ctr + 16'h0101;
    step(1'b0, ctr, c);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 16'hFFFF, 1'b1);
    // locked stream with aligned commas
    for (int i = 0; i < 12; i++) word(i % 6 == 0);
    // sweep comma offset over even and odd half-word positions
    for (int off = 0; off < 12; off++) begin
      for (int k = 0; k < off; k++) word(1'b0);
      word(1'b1);
      for (int k = 0; k < 5; k++) word(1'b0);
    end
    // back-to-back commas
    for (int k = 0; k < 4; k++) word(1'b1);
    for (int k = 0; k < 3; k++) word(1'b0);
    // data pattern sweep across bytes
    for (int k = 0; k < 64; k++) step(1'b0, {k[7:0], ~k[7:0]}, (k % 10) == 3);
    // reset in the middle of a pair
    word(1'b1);
    step(1'b1, 16'hABCD, 1'b0);
    for (int k = 0; k < 6; k++) word(k == 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule